// File: doc/BRIEF.md
# Local Interrupt Controller Configuration Registers

This block is the software-visible configuration register file of a per-core interrupt controller. A simple register bus presents a byte offset, a byte count, a write flag and write data. The block decodes the offset into one register on a 16-byte stride, applies that register's own write mask or read-only rule, and answers one cycle later with read data and an error flag.

The block holds these registers:

- the identity register;
- the task-priority register;
- the logical-destination register;
- the destination-format register;
- the spurious-vector register, whose bit 8 drives a software-enable output;
- a read-only version word;
- six local vector entries;
- an error-status register.

The error-status register gathers error events from the surrounding logic. It clears only through a two-step write, and a read cancels a pending first step.

Top module: `lic_cfg_regs`

## Requirements
- R1: The low three offset bits are ignored when decoding. An access to an offset that maps to no register answers with `resp_err`=1 and `rd_data`=0, and changes no state.
- R2: An access is rejected in the same way as in R1 when its last byte lies in the next 8-byte word, that is when `acc_addr[2:0]` + `acc_len` > 7. `acc_len` is the byte count minus one.
- R3: The identity register (offset 0x020) and the task-priority register (offset 0x080) keep write bits 7:0. Their other bits read as zero.
- R4: The logical-destination register (offset 0x0D0) keeps write bits 31:24. Bits 23:0 read as zero.
- R5: The destination-format register (offset 0x0E0) stores bits 31:28 from the write. Bits 27:0 always read as one.
- R6: The version word (offset 0x030) ignores writes and always reads `VERSION_VAL`.
- R7: The six local vector entries sit at offset 0x320 + 16·k, for k = 0 to 5. Bits 12 and 14 of an entry are read-only and keep their stored value on writes; all other bits take the write data. A write to one entry leaves the others unchanged.
- R8: A write to error status (offset 0x280) when it is not armed only arms it, and the stored value is kept. A write when it is armed clears the stored value and disarms it.
- R9: A read of error status returns the stored value and disarms it.
- R10: The spurious-vector register (offset 0x0F0) stores the full write word. `sw_enable` equals bit 8 of the last value written there.
- R11: A synchronous active-high reset does the following: the destination-format register becomes all ones; every other register becomes zero; `sw_enable` becomes 0; error status becomes not armed.
- R12: Every accepted access cycle (`acc_en`=1) produces `resp_valid`=1 on the next cycle, and no other cycle does. `rd_data` is 0 for writes.
- R13: Each bit set on `err_evt` in a cycle is ORed into error status at that clock edge and stays set until error status is cleared. An event that arrives in the same cycle as the clearing write survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_len | input | 3 | Byte count of the access minus one |
| acc_wdata | input | 32 | Write data |
| err_evt | input | ERR_W | Error events, ORed into error status |
| resp_valid | output | 1 | Response strobe, one cycle after `acc_en` |
| resp_err | output | 1 | The access was rejected |
| rd_data | output | 32 | Read data |
| sw_enable | output | 1 | Software-enable flag taken from the spurious-vector register |

## Verification
The bench builds the block with the default values: a 12-bit offset, six vector entries, 8 error-event bits and the default version word. With these values every defined offset is reachable, and so are the offsets between the defined ones. Both ends of the vector-entry range can be exercised, as can a span exactly at the 8-byte limit and one just over it. Error events can be injected at the same edge as the clearing write, which checks that the arm/clear sequence does not lose an event that lands on the clearing edge.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int DW = 32;

  // register byte offsets, already aligned to the 16-byte stride
  localparam logic [11:0] OFF_IDENT = 12'h020;
  localparam logic [11:0] OFF_VER   = 12'h030;
  localparam logic [11:0] OFF_TPRI  = 12'h080;
  localparam logic [11:0] OFF_LDEST = 12'h0D0;
  localparam logic [11:0] OFF_DFMT  = 12'h0E0;
  localparam logic [11:0] OFF_SPUR  = 12'h0F0;
  localparam logic [11:0] OFF_ESTAT = 12'h280;
  localparam logic [11:0] OFF_LVT0  = 12'h320;

  // write masks and read-only rules
  localparam logic [DW-1:0] MASK_LOW8   = 32'h0000_00FF;
  localparam logic [DW-1:0] MASK_LDEST  = 32'hFF00_0000;
  localparam logic [DW-1:0] FORCE_DFMT  = 32'h0FFF_FFFF;
  localparam logic [DW-1:0] LVT_RO_MASK = 32'h0000_5000;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IDENT,
    SEL_VER,
    SEL_TPRI,
    SEL_LDEST,
    SEL_DFMT,
    SEL_SPUR,
    SEL_ESTAT,
    SEL_LVT
  } reg_sel_e;
endpackage

// File: rtl/lic_addr_decode.sv
module lic_addr_decode
  import lic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_LVT  = 6,
  localparam int IW    = (N_LVT > 1) ? $clog2(N_LVT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        len,
  output reg_sel_e          sel,
  output logic [IW-1:0]     lvt_idx,
  output logic              bad
);
  localparam logic [ADDR_W-1:0] LVT_LO = ADDR_W'(OFF_LVT0);
  localparam logic [ADDR_W-1:0] LVT_HI = ADDR_W'(OFF_LVT0) + ADDR_W'(N_LVT * 16);
  localparam logic [IW-1:0]     BASE_IDX = OFF_LVT0[4 +: IW];

  logic [ADDR_W-1:0] aligned;
  logic              span_over;
  logic [3:0]        last_byte;

  assign aligned   = {addr[ADDR_W-1:3], 3'b000};
  assign last_byte = {1'b0, addr[2:0]} + {1'b0, len};
  assign span_over = last_byte[3];
  assign lvt_idx   = addr[4 +: IW] - BASE_IDX;

  always_comb begin
    sel = SEL_NONE;
    if (aligned == ADDR_W'(OFF_IDENT))      sel = SEL_IDENT;
    else if (aligned == ADDR_W'(OFF_VER))   sel = SEL_VER;
    else if (aligned == ADDR_W'(OFF_TPRI))  sel = SEL_TPRI;
    else if (aligned == ADDR_W'(OFF_LDEST)) sel = SEL_LDEST;
    else if (aligned == ADDR_W'(OFF_DFMT))  sel = SEL_DFMT;
    else if (aligned == ADDR_W'(OFF_SPUR))  sel = SEL_SPUR;
    else if (aligned == ADDR_W'(OFF_ESTAT)) sel = SEL_ESTAT;
    else if (aligned >= LVT_LO && aligned < LVT_HI && !aligned[3])
      sel = SEL_LVT;
  end

  assign bad = span_over || (sel == SEL_NONE);
endmodule

// File: rtl/lic_lvt_bank.sv
module lic_lvt_bank
  import lic_pkg::*;
#(
  parameter int N_LVT = 6,
  localparam int IW   = (N_LVT > 1) ? $clog2(N_LVT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] entry_q [N_LVT];

  for (genvar k = 0; k < N_LVT; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        entry_q[k] <= '0;
      else if (wr_en && idx == IW'(k))
        entry_q[k] <= (wdata & ~LVT_RO_MASK) | (entry_q[k] & LVT_RO_MASK);
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_LVT; k++)
      if (idx == IW'(k)) rdata = entry_q[k];
  end
endmodule

// File: rtl/lic_estat_unit.sv
module lic_estat_unit
  import lic_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [ERR_W-1:0] err_evt,
  output logic [DW-1:0]    value
);
  logic [ERR_W-1:0] stat_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      armed_q <= 1'b0;
    end else if (wr_hit) begin
      if (armed_q) begin
        stat_q  <= err_evt;          // clear, keep same-edge events
        armed_q <= 1'b0;
      end else begin
        stat_q  <= stat_q | err_evt; // first step: arm only
        armed_q <= 1'b1;
      end
    end else begin
      stat_q <= stat_q | err_evt;
      if (rd_hit) armed_q <= 1'b0;
    end
  end

  assign value = DW'(stat_q);
endmodule

// File: rtl/lic_cfg_regs.sv
module lic_cfg_regs
  import lic_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          N_LVT       = 6,
  parameter int          ERR_W       = 8,
  parameter logic [31:0] VERSION_VAL = 32'h0005_0014
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_len,
  input  logic [31:0]       acc_wdata,
  input  logic [ERR_W-1:0]  err_evt,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [31:0]       rd_data,
  output logic              sw_enable
);
  localparam int IW = (N_LVT > 1) ? $clog2(N_LVT) : 1;

  reg_sel_e      sel;
  logic [IW-1:0] lvt_idx;
  logic          bad;
  logic          wr_ok, rd_ok;
  logic [DW-1:0] lvt_rd, est_rd, rd_mux;

  logic [DW-1:0] ident_q, tpri_q, ldest_q, dfmt_q, spur_q;

  lic_addr_decode #(.ADDR_W(ADDR_W), .N_LVT(N_LVT)) u_dec (
    .addr(acc_addr), .len(acc_len), .sel(sel), .lvt_idx(lvt_idx), .bad(bad)
  );

  assign wr_ok = acc_en &&  acc_wr && !bad;
  assign rd_ok = acc_en && !acc_wr && !bad;

  lic_lvt_bank #(.N_LVT(N_LVT)) u_lvt (
    .clk(clk), .rst(rst), .wr_en(wr_ok && sel == SEL_LVT),
    .idx(lvt_idx), .wdata(acc_wdata), .rdata(lvt_rd)
  );

  lic_estat_unit #(.ERR_W(ERR_W)) u_est (
    .clk(clk), .rst(rst),
    .wr_hit(wr_ok && sel == SEL_ESTAT),
    .rd_hit(rd_ok && sel == SEL_ESTAT),
    .err_evt(err_evt), .value(est_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_q <= '0;
      tpri_q  <= '0;
      ldest_q <= '0;
      dfmt_q  <= '1;
      spur_q  <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_IDENT: ident_q <= acc_wdata & MASK_LOW8;
        SEL_TPRI:  tpri_q  <= acc_wdata & MASK_LOW8;
        SEL_LDEST: ldest_q <= acc_wdata & MASK_LDEST;
        SEL_DFMT:  dfmt_q  <= acc_wdata | FORCE_DFMT;
        SEL_SPUR:  spur_q  <= acc_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_IDENT: rd_mux = ident_q;
      SEL_VER:   rd_mux = VERSION_VAL;
      SEL_TPRI:  rd_mux = tpri_q;
      SEL_LDEST: rd_mux = ldest_q;
      SEL_DFMT:  rd_mux = dfmt_q;
      SEL_SPUR:  rd_mux = spur_q;
      SEL_ESTAT: rd_mux = est_rd;
      SEL_LVT:   rd_mux = lvt_rd;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      rd_data    <= '0;
    end else begin
      resp_valid <= acc_en;
      resp_err   <= acc_en && bad;
      rd_data    <= rd_ok ? rd_mux : '0;
    end
  end

  assign sw_enable = spur_q[8];
endmodule

// File: rtl/lic_cfg_regs_chk.sv
module lic_cfg_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [2:0]        acc_len,
  input logic              resp_valid,
  input logic              resp_err,
  input logic [31:0]       rd_data,
  input logic              sw_enable
);
  logic [ADDR_W-1:0] al;
  logic [3:0]        last_b;
  logic              fits;

  assign al     = {acc_addr[ADDR_W-1:3], 3'b000};
  assign last_b = {1'b0, acc_addr[2:0]} + {1'b0, acc_len};
  assign fits   = !last_b[3];

  a_r12_resp_follows: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> resp_valid);
  a_r12_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !resp_valid);
  a_r2_span_reject: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !fits) |=> (resp_err && rd_data == 32'h0));
  a_r1_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> rd_data == 32'h0);
  a_r3_ident_width: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && fits && al == ADDR_W'(12'h020)) |=> rd_data[31:8] == 24'h0);
  a_r4_ldest_width: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && fits && al == ADDR_W'(12'h0D0)) |=> rd_data[23:0] == 24'h0);
  a_r5_dfmt_ones: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && fits && al == ADDR_W'(12'h0E0)) |=> rd_data[27:0] == 28'hFFF_FFFF);
  a_r10_swen_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(sw_enable) |-> $past(acc_en && acc_wr && fits && al == ADDR_W'(12'h0F0)));
endmodule

bind lic_cfg_regs lic_cfg_regs_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .acc_len(acc_len), .resp_valid(resp_valid), .resp_err(resp_err),
  .rd_data(rd_data), .sw_enable(sw_enable)
);

// File: tb/lic_cfg_regs_test.sv
`timescale 1ns/1ps
module lic_cfg_regs_test;
  localparam logic [31:0] VER = 32'h0005_0014;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [2:0]  acc_len = '0;
  logic [31:0] acc_wdata = '0;
  logic [7:0]  err_evt = '0;
  logic        resp_valid, resp_err, sw_enable;
  logic [31:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lic_cfg_regs #(.VERSION_VAL(VER)) uut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_len(acc_len), .acc_wdata(acc_wdata), .err_evt(err_evt),
    .resp_valid(resp_valid), .resp_err(resp_err), .rd_data(rd_data),
    .sw_enable(sw_enable)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [11:0] addr;
    logic [2:0]  len;
    logic [31:0] wd;
    logic        err;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{4'd11, 1'b0, 12'h020, 3'd3, 32'h0, 1'b0, 32'h0},            // R11 ident reset
    '{4'd11, 1'b0, 12'h0E0, 3'd3, 32'h0, 1'b0, 32'hFFFF_FFFF},    // R11 dfmt reset
    '{4'd3,  1'b1, 12'h020, 3'd3, 32'hA5A5_5A3C, 1'b0, 32'h0},
    '{4'd3,  1'b0, 12'h024, 3'd3, 32'h0, 1'b0, 32'h0000_003C},    // R3 + R1 low bits
    '{4'd3,  1'b1, 12'h080, 3'd3, 32'h1234_56F7, 1'b0, 32'h0},
    '{4'd3,  1'b0, 12'h080, 3'd3, 32'h0, 1'b0, 32'h0000_00F7},    // R3 tpri
    '{4'd4,  1'b1, 12'h0D0, 3'd3, 32'hABCD_EF01, 1'b0, 32'h0},
    '{4'd4,  1'b0, 12'h0D0, 3'd3, 32'h0, 1'b0, 32'hAB00_0000},    // R4
    '{4'd5,  1'b1, 12'h0E0, 3'd3, 32'h5000_0000, 1'b0, 32'h0},
    '{4'd5,  1'b0, 12'h0E0, 3'd3, 32'h0, 1'b0, 32'h5FFF_FFFF},    // R5
    '{4'd6,  1'b1, 12'h030, 3'd3, 32'hDEAD_BEEF, 1'b0, 32'h0},
    '{4'd6,  1'b0, 12'h030, 3'd3, 32'h0, 1'b0, VER},              // R6
    '{4'd7,  1'b1, 12'h320, 3'd3, 32'hFFFF_FFFF, 1'b0, 32'h0},
    '{4'd7,  1'b0, 12'h320, 3'd3, 32'h0, 1'b0, 32'hFFFF_AFFF},    // R7 first entry
    '{4'd7,  1'b1, 12'h370, 3'd3, 32'h0000_5A5A, 1'b0, 32'h0},
    '{4'd7,  1'b0, 12'h370, 3'd3, 32'h0, 1'b0, 32'h0000_0A5A},    // R7 last entry
    '{4'd7,  1'b0, 12'h330, 3'd3, 32'h0, 1'b0, 32'h0},            // R7 independence
    '{4'd1,  1'b0, 12'h040, 3'd3, 32'h0, 1'b1, 32'h0},            // R1 undefined read
    '{4'd1,  1'b1, 12'h028, 3'd3, 32'hFFFF_FFFF, 1'b1, 32'h0},    // R1 undefined write
    '{4'd2,  1'b0, 12'h025, 3'd3, 32'h0, 1'b1, 32'h0},            // R2 span over
    '{4'd2,  1'b1, 12'h085, 3'd3, 32'h0000_0011, 1'b1, 32'h0},    // R2 rejected write
    '{4'd2,  1'b0, 12'h084, 3'd3, 32'h0, 1'b0, 32'h0000_00F7},    // R2 limit, no effect
    '{4'd7,  1'b0, 12'h320, 3'd7, 32'h0, 1'b0, 32'hFFFF_AFFF}     // R7 full 8-byte span
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [2:0] l,
                        input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_len = l; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R11", "sw_enable after reset", 32'(sw_enable), 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr, VEC[i].len, VEC[i].wd);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rd_data", i), rd_data, VEC[i].exp);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d resp_err", i), 32'(resp_err), 32'(VEC[i].err));
      check("R12", $sformatf("vec %0d resp_valid", i), 32'(resp_valid), 32'h1);
    end
    @(negedge clk);
    check("R12", "idle resp_valid", 32'(resp_valid), 32'h0);

    // R13: event accumulation
    @(negedge clk); err_evt = 8'h05;
    @(negedge clk); err_evt = 8'h00;
    access(1'b0, 12'h280, 3'd3, 32'h0);
    check("R13", "events latched", rd_data, 32'h05);
    // R8: single write only arms
    access(1'b1, 12'h280, 3'd3, 32'h0);
    access(1'b0, 12'h280, 3'd3, 32'h0);
    check("R8", "unarmed write keeps value", rd_data, 32'h05);
    // R8: arm then clear
    access(1'b1, 12'h280, 3'd3, 32'h0);
    access(1'b1, 12'h280, 3'd3, 32'h0);
    access(1'b0, 12'h280, 3'd3, 32'h0);
    check("R8", "armed write clears", rd_data, 32'h0);
    // R9: read between two writes disarms
    @(negedge clk); err_evt = 8'h30;
    @(negedge clk); err_evt = 8'h00;
    access(1'b1, 12'h280, 3'd3, 32'h0);
    access(1'b0, 12'h280, 3'd3, 32'h0);
    check("R9", "read returns value", rd_data, 32'h30);
    access(1'b1, 12'h280, 3'd3, 32'h0);
    access(1'b0, 12'h280, 3'd3, 32'h0);
    check("R9", "read disarmed, write re-armed only", rd_data, 32'h30);
    // R13: event on the clearing edge survives
    access(1'b1, 12'h280, 3'd3, 32'h0);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 12'h280; acc_len = 3'd3; err_evt = 8'h80;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; err_evt = 8'h00;
    access(1'b0, 12'h280, 3'd3, 32'h0);
    check("R13", "same-edge event kept", rd_data, 32'h80);

    // R10: spurious-vector register and sw_enable
    access(1'b1, 12'h0F0, 3'd3, 32'h0000_01FF);
    check("R10", "sw_enable set", 32'(sw_enable), 32'h1);
    access(1'b0, 12'h0F0, 3'd3, 32'h0);
    check("R10", "spur readback", rd_data, 32'h0000_01FF);
    check("R12", "read resp_valid", 32'(resp_valid), 32'h1);
    access(1'b1, 12'h0F0, 3'd3, 32'h0000_00FF);
    check("R10", "sw_enable cleared", 32'(sw_enable), 32'h0);
    access(1'b1, 12'h0F0, 3'd3, 32'h0000_0100);
    check("R12", "write rd_data zero", rd_data, 32'h0);

    // R11: reset mid-run; arm flag cleared too
    access(1'b1, 12'h280, 3'd3, 32'h0);
    @(negedge clk); err_evt = 8'h44;
    @(negedge clk); err_evt = 8'h00;
    do_reset();
    check("R11", "sw_enable after mid reset", 32'(sw_enable), 32'h0);
    access(1'b0, 12'h020, 3'd3, 32'h0);
    check("R11", "ident after reset", rd_data, 32'h0);
    access(1'b0, 12'h0E0, 3'd3, 32'h0);
    check("R11", "dfmt after reset", rd_data, 32'hFFFF_FFFF);
    access(1'b0, 12'h370, 3'd3, 32'h0);
    check("R11", "lvt after reset", rd_data, 32'h0);
    @(negedge clk); err_evt = 8'h02;
    @(negedge clk); err_evt = 8'h00;
    access(1'b1, 12'h280, 3'd3, 32'h0);
    access(1'b0, 12'h280, 3'd3, 32'h0);
    check("R11", "reset disarms error status", rd_data, 32'h02);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule